// File: doc/BRIEF.md
# UART Interrupt and DMA Request Controller

This block sits beside a serial port and turns the port's event flags into a single interrupt line and two DMA request lines. The flags it takes in are the FIFO level flags, a receive timeout, the three receive error kinds, two break indications, transmit-empty and transmit-complete, and the CTS pin. A 32-bit control word picks, for each direction, whether data moves by DMA or by interrupt. It also enables each interrupt group, sets the CTS edge condition and holds a six-bit status-change source mask.

Each event class has a sticky status bit. Software reads these bits over a simple register bus and clears them by writing 1. CTS first passes through a synchronizer. An edge detector then qualifies it against the programmed condition, and the result is one of the six status-change sources. Any enabled status-change source sets a sticky change flag. That flag always drives the interrupt, whatever the other enables are.

Register bus: address 0 is the control word and address 1 is the status word. Reads are combinational while `bus_en` is high and `bus_we` is low. Writes take effect at the next clock edge.

Top module: `uic_top`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, and `irq`, `tx_dma_req` and `rx_dma_req` are all low.
- R2: The control word fields sit at these bits:
  - bit 15: transmit DMA enable.
  - bit 14: receive DMA enable.
  - bit 13: transmit-room interrupt enable.
  - bit 12: receive interrupt enable.
  - bit 11: error interrupt enable.
  - bits 10:9: CTS condition.
  - bits 5:0: status-change mask.

  All other bits read 0, so writing all ones reads back 0x0000FE3F.
- R3: `tx_dma_req` equals `tx_space` and `rx_dma_req` equals `rx_full` in the same cycle while the matching DMA enable (bit 15 or bit 14) is set. Each line is held low while its enable is clear.
- R4: Status bits are set at the clock edge that samples their source. They stay set until software writes 1 to that bit at address 1. A set in the same cycle as a clear wins.
- R5: The interrupt is the OR of three gated terms and the change flag:
  - status bit 0 gated by control bit 13;
  - status bit 1 gated by control bit 12;
  - status bit 2 gated by control bit 11;
  - status bit 3, which needs no enable.
- R6: Status bit 0 is set by `tx_space`. Status bit 1 is set by `rx_full` or `rx_timeout`. Status bit 2 is set by `err_frame`, `err_parity` or `err_overrun`.
- R7: The CTS condition encodes 00 as ignore, 01 as rising edge, 10 as falling edge and 11 as both edges. A qualified CTS edge sets status bit 8 at the third clock edge after the pin changes.
- R8: Mask bit i enables status-change source i:
  - bit 5: overrun;
  - bit 4: qualified CTS change;
  - bit 3: receive break rising;
  - bit 2: transmit-empty rising;
  - bit 1: transmit-complete rising;
  - bit 0: break detect rising.

  Status bit 4+i records source i whatever the mask holds. Status bit 3 (the change flag) is set only by a source whose mask bit is set.
- R9: Overrun is a level source and sets its bits again every cycle while it stays high. The four flag sources in R8 act only on a rising edge, so a held-high flag does not set its bits again after they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | ADDR_W | 0 = control word, 1 = status word |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, combinational |
| tx_space | input | 1 | Transmit FIFO has free room |
| rx_full | input | 1 | Receive FIFO has reached its fill level |
| rx_timeout | input | 1 | Receive timeout |
| err_frame | input | 1 | Framing error |
| err_parity | input | 1 | Parity error |
| err_overrun | input | 1 | Overrun error |
| rx_break | input | 1 | Receive break flag |
| brk_detect | input | 1 | Break detection flag |
| tx_empty | input | 1 | Transmit data empty flag |
| tx_done | input | 1 | Transmission complete flag |
| cts_in | input | 1 | Asynchronous CTS pin |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Each result in this block is due at a different point after its stimulus:
- Register reads and both DMA lines are combinational, so they are due in the same cycle as the stimulus.
- Status bits and the interrupt (in its default form) are due one clock edge after a source is sampled.
- A CTS-qualified status bit is due at the third edge after the pin changes.

The driver changes inputs just after a rising edge. The monitor compares at the next falling edge, after the due edge has passed. One CTS check reads the status at the second edge to confirm the bit is still clear, then reads again after the third edge.

// File: rtl/uic_pkg.sv
package uic_pkg;

   // Control word bit positions
   localparam int CTL_TDE     = 15;
   localparam int CTL_RDE     = 14;
   localparam int CTL_TIE     = 13;
   localparam int CTL_RIE     = 12;
   localparam int CTL_EIE     = 11;
   localparam int CTL_CTS_LO  = 9;
   localparam int CTL_MASK_LO = 0;
   localparam int N_CHG       = 6;

   // Status word bit positions
   localparam int ST_TX     = 0;
   localparam int ST_RX     = 1;
   localparam int ST_ERR    = 2;
   localparam int ST_CHG    = 3;
   localparam int ST_SRC_LO = 4;
   localparam int ST_BITS   = ST_SRC_LO + N_CHG;

   // Status-change source indices (mask bit i selects source i)
   localparam int SRC_BDET    = 0;
   localparam int SRC_TXDONE  = 1;
   localparam int SRC_TXEMPTY = 2;
   localparam int SRC_RBRK    = 3;
   localparam int SRC_CTS     = 4;
   localparam int SRC_OVR     = 5;

   typedef enum logic [1:0] {
      CTS_OFF  = 2'b00,
      CTS_RISE = 2'b01,
      CTS_FALL = 2'b10,
      CTS_BOTH = 2'b11
   } cts_cond_e;

   typedef struct packed {
      logic             tde;
      logic             rde;
      logic             tie;
      logic             rie;
      logic             eie;
      cts_cond_e        cts;
      logic [N_CHG-1:0] mask;
   } ctl_t;

endpackage

// File: rtl/uic_ctl_reg.sv
module uic_ctl_reg
   import uic_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output ctl_t             ctl,
   output logic [REG_W-1:0] rd_val
);

   ctl_t ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q.tde  <= wdata[CTL_TDE];
         ctl_q.rde  <= wdata[CTL_RDE];
         ctl_q.tie  <= wdata[CTL_TIE];
         ctl_q.rie  <= wdata[CTL_RIE];
         ctl_q.eie  <= wdata[CTL_EIE];
         ctl_q.cts  <= cts_cond_e'(wdata[CTL_CTS_LO +: 2]);
         ctl_q.mask <= wdata[CTL_MASK_LO +: N_CHG];
      end
   end

   always_comb begin
      rd_val                      = '0;
      rd_val[CTL_TDE]             = ctl_q.tde;
      rd_val[CTL_RDE]             = ctl_q.rde;
      rd_val[CTL_TIE]             = ctl_q.tie;
      rd_val[CTL_RIE]             = ctl_q.rie;
      rd_val[CTL_EIE]             = ctl_q.eie;
      rd_val[CTL_CTS_LO +: 2]     = ctl_q.cts;
      rd_val[CTL_MASK_LO +: N_CHG] = ctl_q.mask;
   end

   assign ctl = ctl_q;

endmodule

// File: rtl/uic_sync_edge.sv
module uic_sync_edge
   import uic_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      din,
   input  cts_cond_e cond,
   output logic      evt
);

   logic [STAGES-1:0] sh_q;
   logic              prev_q;
   logic              sync_s;
   logic              rise_s;
   logic              fall_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], din};
         prev_q <= sync_s;
      end
   end

   assign sync_s = sh_q[STAGES-1];
   assign rise_s = sync_s & ~prev_q;
   assign fall_s = ~sync_s & prev_q;

   always_comb begin
      unique case (cond)
         CTS_RISE: evt = rise_s;
         CTS_FALL: evt = fall_s;
         CTS_BOTH: evt = rise_s | fall_s;
         default:  evt = 1'b0;
      endcase
   end

endmodule

// File: rtl/uic_rise.sv
module uic_rise #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags,
   output logic [W-1:0] rise
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= flags;
   end

   for (genvar i = 0; i < W; i++) begin : g_rise
      assign rise[i] = flags[i] & ~prev_q[i];
   end

endmodule

// File: rtl/uic_status.sv
module uic_status
   import uic_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int N_SRC = N_CHG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_tx,
   input  logic             set_rx,
   input  logic             set_err,
   input  logic [N_SRC-1:0] src_evt,
   input  logic [N_SRC-1:0] mask,
   input  logic             clr_we,
   input  logic [REG_W-1:0] clr_data,
   output logic [REG_W-1:0] st
);

   localparam int NB = ST_SRC_LO + N_SRC;

   logic [NB-1:0] q;
   logic [NB-1:0] set_v;
   logic [NB-1:0] clr_v;

   assign set_v[ST_TX]  = set_tx;
   assign set_v[ST_RX]  = set_rx;
   assign set_v[ST_ERR] = set_err;
   assign set_v[ST_CHG] = |(src_evt & mask);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign set_v[ST_SRC_LO + i] = src_evt[i];
   end

   assign clr_v = clr_we ? clr_data[NB-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= set_v | (q & ~clr_v);
   end

   if (REG_W > NB) begin : g_pad
      assign st = {{(REG_W-NB){1'b0}}, q};
   end else begin : g_nopad
      assign st = q;
   end

endmodule

// File: rtl/uic_top.sv
module uic_top
   import uic_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int IRQ_REG     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              tx_space,
   input  logic              rx_full,
   input  logic              rx_timeout,
   input  logic              err_frame,
   input  logic              err_parity,
   input  logic              err_overrun,
   input  logic              rx_break,
   input  logic              brk_detect,
   input  logic              tx_empty,
   input  logic              tx_done,
   input  logic              cts_in,
   output logic              irq,
   output logic              tx_dma_req,
   output logic              rx_dma_req
);

   localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);
   localparam int                N_FLAG    = 4;

   // Elaboration-time parameter checks
   if (REG_W < 16 || REG_W < ST_BITS) begin : g_bad_regw
      $error("uic_top: REG_W must hold the control and status fields");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("uic_top: ADDR_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uic_top: SYNC_STAGES must be at least 2");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("uic_top: IRQ_REG must be 0 or 1");
   end

   ctl_t             ctl;
   logic [REG_W-1:0] ctl_rd;
   logic [REG_W-1:0] st_vec;
   logic             ctl_wr;
   logic             st_wr;
   logic             cts_evt;
   logic [N_FLAG-1:0] flag_v;
   logic [N_FLAG-1:0] flag_rise;
   logic [N_CHG-1:0] src_evt;
   logic             irq_d;

   assign ctl_wr = bus_en & bus_we & (bus_addr == CTL_ADDR);
   assign st_wr  = bus_en & bus_we & (bus_addr == STAT_ADDR);

   uic_ctl_reg #(.REG_W(REG_W)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ctl_wr),
      .wdata  (bus_wdata),
      .ctl    (ctl),
      .rd_val (ctl_rd)
   );

   uic_sync_edge #(.STAGES(SYNC_STAGES)) u_cts (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cts_in),
      .cond  (ctl.cts),
      .evt   (cts_evt)
   );

   assign flag_v = {brk_detect, tx_done, tx_empty, rx_break};

   uic_rise #(.W(N_FLAG)) u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flag_v),
      .rise  (flag_rise)
   );

   always_comb begin
      src_evt              = '0;
      src_evt[SRC_RBRK]    = flag_rise[0];
      src_evt[SRC_TXEMPTY] = flag_rise[1];
      src_evt[SRC_TXDONE]  = flag_rise[2];
      src_evt[SRC_BDET]    = flag_rise[3];
      src_evt[SRC_CTS]     = cts_evt;
      src_evt[SRC_OVR]     = err_overrun;
   end

   uic_status #(.REG_W(REG_W), .N_SRC(N_CHG)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_tx   (tx_space),
      .set_rx   (rx_full | rx_timeout),
      .set_err  (err_frame | err_parity | err_overrun),
      .src_evt  (src_evt),
      .mask     (ctl.mask),
      .clr_we   (st_wr),
      .clr_data (bus_wdata),
      .st       (st_vec)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         if (bus_addr == CTL_ADDR)       bus_rdata = ctl_rd;
         else if (bus_addr == STAT_ADDR) bus_rdata = st_vec;
      end
   end

   assign irq_d = (ctl.tie & st_vec[ST_TX])
                | (ctl.rie & st_vec[ST_RX])
                | (ctl.eie & st_vec[ST_ERR])
                | st_vec[ST_CHG];

   if (IRQ_REG != 0) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_d;
   end

   assign tx_dma_req = ctl.tde & tx_space;
   assign rx_dma_req = ctl.rde & rx_full;

endmodule

// File: rtl/uic_chk.sv
module uic_chk
   import uic_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int ADDR_W  = 2,
   parameter int IRQ_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  bus_rdata,
   input logic              tx_space,
   input logic              rx_full,
   input logic              irq,
   input logic              tx_dma_req,
   input logic              rx_dma_req,
   input ctl_t              ctl,
   input logic [REG_W-1:0]  st_vec
);

   logic clr_tx;
   logic clr_chg;
   assign clr_tx  = bus_en && bus_we && (bus_addr == ADDR_W'(1)) && bus_wdata[ST_TX];
   assign clr_chg = bus_en && bus_we && (bus_addr == ADDR_W'(1)) && bus_wdata[ST_CHG];

   // R2
   ctl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == ADDR_W'(0)) |-> ((bus_rdata & ~REG_W'(32'h0000_FE3F)) == '0));

   // R3
   tx_dma_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req |-> tx_space);

   // R3
   rx_dma_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> rx_full);

   // R4
   tx_set_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_space |=> st_vec[ST_TX]);

   // R4
   tx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_vec[ST_TX] && !clr_tx) |=> st_vec[ST_TX]);

   // R4
   chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_vec[ST_CHG] && !clr_chg) |=> st_vec[ST_CHG]);

   // R7
   cts_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.cts == CTS_OFF) |=> !$rose(st_vec[ST_SRC_LO + SRC_CTS]));

   if (IRQ_REG == 0) begin : g_comb
      // R8
      chg_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         st_vec[ST_CHG] |-> irq);
   end else begin : g_reg
      // R8
      chg_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (st_vec[ST_CHG] && !clr_chg) |=> irq);
   end

endmodule

bind uic_top uic_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_en     (bus_en),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .tx_space   (tx_space),
   .rx_full    (rx_full),
   .irq        (irq),
   .tx_dma_req (tx_dma_req),
   .rx_dma_req (rx_dma_req),
   .ctl        (ctl),
   .st_vec     (st_vec)
);

// File: tb/uic_top_tb.sv
`timescale 1ns/1ps
module uic_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic tx_space = 0, rx_full = 0, rx_timeout = 0;
   logic err_frame = 0, err_parity = 0, err_overrun = 0;
   logic rx_break = 0, brk_detect = 0, tx_empty = 0, tx_done = 0, cts_in = 0;
   logic irq, tx_dma_req, rx_dma_req;

   logic chk_stb = 1'b0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 0;

   int          kq[$];
   logic [31:0] eq[$];
   string       tq[$];

   always #10 clk = ~clk;

   uic_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_space(tx_space), .rx_full(rx_full), .rx_timeout(rx_timeout),
      .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
      .rx_break(rx_break), .brk_detect(brk_detect), .tx_empty(tx_empty),
      .tx_done(tx_done), .cts_in(cts_in),
      .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
   );

   // Monitor: compares at the falling edge
   always @(negedge clk) begin
      if ((bus_en && !bus_we) || chk_stb) begin
         if (kq.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard: result with no expected item");
         end else begin
            int          k;
            logic [31:0] e;
            logic [31:0] a;
            string       t;
            k = kq.pop_front();
            e = eq.pop_front();
            t = tq.pop_front();
            case (k)
               0: a = bus_rdata;
               1: a = {31'd0, irq};
               2: a = {31'd0, tx_dma_req};
               default: a = {31'd0, rx_dma_req};
            endcase
            n_cmp++;
            if (a !== e) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", t, a, e);
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      tick(1);
      bus_en = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
      kq.push_back(0); eq.push_back(e); tq.push_back(t);
      bus_en = 1; bus_we = 0; bus_addr = a;
      tick(1);
      bus_en = 0;
   endtask

   task automatic chk(input int k, input logic e, input string t);
      kq.push_back(k); eq.push_back({31'd0, e}); tq.push_back(t);
      chk_stb = 1;
      tick(1);
      chk_stb = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      // R1
      rd(0, 32'h0, "R1 control after reset");
      rd(1, 32'h0, "R1 status after reset");
      chk(1, 0, "R1 irq after reset");
      chk(2, 0, "R1 tx dma after reset");
      chk(3, 0, "R1 rx dma after reset");
      // R2
      wr(0, 32'hFFFF_FFFF);
      rd(0, 32'h0000_FE3F, "R2 reserved bits read zero");
      wr(0, 32'h0000_8000);
      rd(0, 32'h0000_8000, "R2 transmit DMA enable at bit 15");
      // R3
      tx_space = 1;
      chk(2, 1, "R3 tx dma follows room");
      tx_space = 0;
      chk(2, 0, "R3 tx dma drops with room");
      rx_full = 1;
      chk(3, 0, "R3 rx dma low while disabled");
      wr(0, 32'h0000_4000);
      chk(3, 1, "R3 rx dma follows data");
      rx_full = 0;
      chk(3, 0, "R3 rx dma drops");
      wr(0, 32'h0);
      wr(1, 32'h3FF);
      rd(1, 32'h0, "R4 all bits cleared");
      // R4 / R5 / R6
      tx_space = 1; tick(1); tx_space = 0;
      rd(1, 32'h1, "R6 room sets bit 0");
      chk(1, 0, "R5 irq gated off");
      wr(0, 32'h0000_2000);
      chk(1, 1, "R5 irq with room enable");
      wr(1, 32'h1);
      rd(1, 32'h0, "R4 write one clears");
      chk(1, 0, "R5 irq after clear");
      tx_space = 1; tick(1);
      wr(1, 32'h1);
      rd(1, 32'h1, "R4 set wins over clear");
      tx_space = 0;
      wr(1, 32'h1);
      wr(0, 32'h0);
      rx_timeout = 1; tick(1); rx_timeout = 0;
      rd(1, 32'h2, "R6 timeout sets bit 1");
      wr(0, 32'h0000_1000);
      chk(1, 1, "R5 irq with receive enable");
      wr(1, 32'h2);
      wr(0, 32'h0);
      err_parity = 1; tick(1); err_parity = 0;
      rd(1, 32'h4, "R6 parity sets bit 2");
      wr(1, 32'h4);
      err_overrun = 1; tick(1); err_overrun = 0;
      rd(1, 32'h204, "R8 overrun recorded while masked off");
      wr(0, 32'h0000_0800);
      chk(1, 1, "R5 irq with error enable");
      wr(1, 32'h3FF);
      wr(0, 32'h0);
      // R7
      wr(0, 32'h0000_0200);
      cts_in = 1; tick(2);
      rd(1, 32'h0, "R7 cts not yet at second edge");
      rd(1, 32'h100, "R7 cts rise at third edge");
      wr(1, 32'h100);
      cts_in = 0; tick(4);
      rd(1, 32'h0, "R7 fall ignored by rise condition");
      wr(0, 32'h0000_0400);
      cts_in = 1; tick(4);
      rd(1, 32'h0, "R7 rise ignored by fall condition");
      cts_in = 0; tick(4);
      rd(1, 32'h100, "R7 fall condition");
      wr(1, 32'h100);
      wr(0, 32'h0000_0600);
      cts_in = 1; tick(4);
      rd(1, 32'h100, "R7 both rise");
      wr(1, 32'h100);
      cts_in = 0; tick(4);
      rd(1, 32'h100, "R7 both fall");
      wr(1, 32'h100);
      wr(0, 32'h0);
      cts_in = 1; tick(4);
      rd(1, 32'h0, "R7 off condition");
      cts_in = 0; tick(4);
      // R8
      wr(0, 32'h0000_0004);
      tx_empty = 1; tick(1); tx_empty = 0;
      rd(1, 32'h48, "R8 tx empty source sets change flag");
      chk(1, 1, "R8 change flag drives irq");
      tx_done = 1; tick(1); tx_done = 0;
      rd(1, 32'h68, "R8 unmasked source only recorded");
      wr(1, 32'h3FF);
      chk(1, 0, "R8 irq after clear");
      wr(0, 32'h0000_0001);
      brk_detect = 1; tick(1); brk_detect = 0;
      rd(1, 32'h18, "R8 break detect source");
      wr(1, 32'h3FF);
      // R9
      wr(0, 32'h0000_0020);
      err_overrun = 1; tick(1);
      rd(1, 32'h20C, "R9 overrun level sets change");
      wr(1, 32'h20C);
      rd(1, 32'h20C, "R9 overrun level sets again");
      err_overrun = 0;
      wr(1, 32'h3FF);
      wr(0, 32'h0000_0004);
      tx_empty = 1; tick(1);
      rd(1, 32'h48, "R9 tx empty edge");
      wr(1, 32'h48);
      rd(1, 32'h0, "R9 held flag does not set again");
      tx_empty = 0;
      tick(2);
      finish_run();
   end

endmodule